// File: doc/BRIEF.md
# Mixed-Frame 64b/66b Block Encoder

This block turns a four-lane byte stream into 66-bit line blocks. Each lane carries one byte and a flag that marks the byte as a control character. The encoder pairs consecutive accepted transfers into an eight-octet group. Octets 0 to 3 are lanes 0 to 3 of the earlier transfer, and octets 4 to 7 are lanes 0 to 3 of the later one. It then works out which of twelve legal layouts the group follows. A group of data alone goes out unchanged behind a data header. Any other group goes out behind a mixed header. In a mixed block, the first payload octet holds a TYPE value that names the layout. Start and terminate characters are implied by that layout and are not stored. The data octets come next, and the remaining control characters are squeezed into 7-bit fields at the right end of the payload.

A group that fits no layout is replaced by an all-control block in which every field holds the error code. Scrambling, rate matching and serialisation belong to later stages.

Both sides use valid/ready. A transfer moves on a clock edge where `in_valid` and `in_ready` are both high, and a block moves where `out_valid` and `out_ready` are both high. `in_ready` depends only on the output register: it is high when that register is empty or is being drained in the same cycle. A producer may therefore hold `in_valid` without watching `in_ready` combinationally. While the sink holds `out_ready` low, the pending block stays unchanged and no further transfer is taken, including the first half of the next group.

Top module: `mixblk_encoder`

## Requirements
- R1: Lane k sits on `in_data[8k+7:8k]` and `in_ctrl[k]`. After reset the first accepted transfer supplies octets 0 to 3 and the second supplies octets 4 to 7. One block is produced for every two accepted transfers.
- R2: If no octet of the group is control, the block is header `01` in bits [65:64], followed by octet 0 in [63:56] and so on down to octet 7 in [7:0].
- R3: Every other block uses header `10`. Header values 00 and 11 never appear. Bits [63:56] carry TYPE, the extended-Hamming codeword of a 4-bit layout index n: {n[3:0], n0^n1^n3, n0^n2^n3, n1^n2^n3, even-parity bit over the seven}. As a result, any two TYPE values differ in at least 4 bits.
- R4: There are two start layouts. The first is start at octet 0 followed by seven data octets (index 1). The second is four control octets, then start at octet 4, then three data octets (index 2).
- R5: The end layouts have terminate at octet p (p = 0 to 7), data in every octet before p and control in every octet after p. Their index is 3+p.
- R6: A group of eight recognised control characters that matches none of the layouts above uses index 11, with all eight characters carried.
- R7: Input control bytes map to 7-bit codes as follows: 0xBC gives 0x00 (idle-even), 0x1C gives 0x01 (idle-odd), 0xFE gives 0x1E (error), 0xFB gives 0x2B (start) and 0xFD gives 0x2D (terminate). Any other byte flagged as control is unrecognised.
- R8: In a mixed block, the data octets fill downward from bit 55 in time order. The carried control codes occupy the lowest 7·n bits, with the earliest in time in the highest field. Bits between the two regions are zero.
- R9: A group that matches no layout becomes header `10`, TYPE of index 11, and eight fields of 0x1E.
- R10: `in_ready` equals `!out_valid || out_ready`. A block appears on the edge that accepts the second transfer of its group. While `out_valid` is high and `out_ready` is low, `out_block` holds its value.
- R11: Reset, active low, clears `out_valid` and drops any half-collected group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset |
| in_valid | input | 1 | Transfer offered |
| in_ready | output | 1 | Transfer can be taken this cycle |
| in_data | input | 32 | Four lane bytes, lane 0 lowest |
| in_ctrl | input | 4 | Per-lane control flag |
| out_valid | output | 1 | Block held in the output register |
| out_ready | input | 1 | Sink takes the block this cycle |
| out_block | output | 66 | Header in [65:64], payload in [63:0] |

## Verification
The critical overlap is an edge where the sink drains the pending block and the second transfer of the next group is accepted at the same moment. In that case the output register must both retire the old block and load the new one. The bench creates this overlap by driving `out_ready` high most of the time while offering transfers with a random gap pattern. It also creates the opposite case with stalls of random length, during which the held block and a low `in_ready` are checked on every cycle. Each block that leaves is compared, in order, against a bench model of the layouts, so a dropped block, a repeated block or a misaligned group shows up as a miscompare.

// File: rtl/mixblk_pkg.sv
package mixblk_pkg;
  localparam int LANES   = 4;
  localparam int BYTE_W  = 8;
  localparam int OCTETS  = 2 * LANES;
  localparam int GRP_W   = OCTETS * BYTE_W;
  localparam int CODE_W  = 7;
  localparam int HDR_W   = 2;
  localparam int PAY_W   = OCTETS * BYTE_W;
  localparam int BLK_W   = HDR_W + PAY_W;
  localparam int FMT_W   = 4;
  localparam int BODY_W  = PAY_W - BYTE_W;

  localparam logic [HDR_W-1:0] HDR_DATA  = 2'b01;
  localparam logic [HDR_W-1:0] HDR_MIXED = 2'b10;

  localparam logic [BYTE_W-1:0] IN_IDLE_E = 8'hBC;
  localparam logic [BYTE_W-1:0] IN_IDLE_O = 8'h1C;
  localparam logic [BYTE_W-1:0] IN_ERR    = 8'hFE;
  localparam logic [BYTE_W-1:0] IN_START  = 8'hFB;
  localparam logic [BYTE_W-1:0] IN_TERM   = 8'hFD;

  localparam logic [CODE_W-1:0] C7_IDLE_E = 7'h00;
  localparam logic [CODE_W-1:0] C7_IDLE_O = 7'h01;
  localparam logic [CODE_W-1:0] C7_ERR    = 7'h1E;
  localparam logic [CODE_W-1:0] C7_START  = 7'h2B;
  localparam logic [CODE_W-1:0] C7_TERM   = 7'h2D;

  localparam logic [FMT_W-1:0] FMT_DATA     = 4'd0;
  localparam logic [FMT_W-1:0] FMT_SOP_LO   = 4'd1;
  localparam logic [FMT_W-1:0] FMT_SOP_HI   = 4'd2;
  localparam logic [FMT_W-1:0] FMT_EOP_BASE = 4'd3;
  localparam logic [FMT_W-1:0] FMT_GAP      = 4'd11;
  localparam logic [FMT_W-1:0] FMT_BAD      = 4'd12;

  typedef struct packed {
    logic              ok;
    logic [CODE_W-1:0] code;
  } cmap_t;

  function automatic cmap_t map_ctl(input logic [BYTE_W-1:0] b);
    cmap_t r;
    r.ok = 1'b1;
    case (b)
      IN_IDLE_E: r.code = C7_IDLE_E;
      IN_IDLE_O: r.code = C7_IDLE_O;
      IN_ERR:    r.code = C7_ERR;
      IN_START:  r.code = C7_START;
      IN_TERM:   r.code = C7_TERM;
      default: begin
        r.ok   = 1'b0;
        r.code = C7_ERR;
      end
    endcase
    return r;
  endfunction

  // extended Hamming (8,4) codeword of the layout index
  function automatic logic [BYTE_W-1:0] type_of(input logic [FMT_W-1:0] f);
    logic [FMT_W-1:0] n;
    logic [6:0]       s;
    n = (f == FMT_BAD) ? FMT_GAP : f;
    s = {n, n[0]^n[1]^n[3], n[0]^n[2]^n[3], n[1]^n[2]^n[3]};
    return {s, ^s};
  endfunction
endpackage

// File: rtl/mixblk_gather.sv
module mixblk_gather
  import mixblk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic [LANES*BYTE_W-1:0] in_data,
  input  logic [LANES-1:0]        in_ctrl,
  output logic [GRP_W-1:0]        grp_data,
  output logic [OCTETS-1:0]       grp_ctrl,
  output logic                    grp_last
);
  logic                    phase_q;
  logic [LANES*BYTE_W-1:0] hold_d_q;
  logic [LANES-1:0]        hold_c_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      hold_d_q <= '0;
      hold_c_q <= '0;
    end else if (take) begin
      phase_q <= ~phase_q;
      if (!phase_q) begin
        hold_d_q <= in_data;
        hold_c_q <= in_ctrl;
      end
    end
  end

  assign grp_last = take & phase_q;
  assign grp_data = {in_data, hold_d_q};
  assign grp_ctrl = {in_ctrl, hold_c_q};
endmodule

// File: rtl/mixblk_classify.sv
module mixblk_classify
  import mixblk_pkg::*;
(
  input  logic [GRP_W-1:0]         grp_data,
  input  logic [OCTETS-1:0]        grp_ctrl,
  output logic [FMT_W-1:0]         fmt,
  output logic [OCTETS-1:0]        keep_d,
  output logic [OCTETS-1:0]        keep_c,
  output logic [OCTETS*CODE_W-1:0] codes
);
  localparam logic [OCTETS-1:0] ALL1   = {OCTETS{1'b1}};
  localparam logic [OCTETS-1:0] LO_ONE = OCTETS'(1);
  localparam logic [OCTETS-1:0] HI_PRE = OCTETS'((1 << (LANES + 1)) - 1);

  logic [OCTETS-1:0] ok, is_s, is_t;

  for (genvar o = 0; o < OCTETS; o++) begin : g_oct
    cmap_t m;
    assign m    = map_ctl(grp_data[o*BYTE_W +: BYTE_W]);
    assign ok[o]   = grp_ctrl[o] & m.ok;
    assign is_s[o] = grp_ctrl[o] & (grp_data[o*BYTE_W +: BYTE_W] == IN_START);
    assign is_t[o] = grp_ctrl[o] & (grp_data[o*BYTE_W +: BYTE_W] == IN_TERM);
    assign codes[o*CODE_W +: CODE_W] = m.code;
  end

  int                first;
  logic              found;
  logic [OCTETS-1:0] tail;
  logic              sop_lo, sop_hi, eop, gap;

  always_comb begin
    first = 0;
    found = 1'b0;
    for (int o = 0; o < OCTETS; o++) begin
      if (grp_ctrl[o] && !found) begin
        first = o;
        found = 1'b1;
      end
    end
    tail   = ALL1 << first;
    sop_lo = is_s[0] && (grp_ctrl == LO_ONE);
    sop_hi = is_s[LANES] && (grp_ctrl == HI_PRE) && ((ok & HI_PRE) == HI_PRE);
    eop    = found && is_t[first] && (grp_ctrl == tail) && ((ok & tail) == tail);
    gap    = (ok == ALL1);

    keep_d = ~grp_ctrl;
    keep_c = grp_ctrl;
    if (grp_ctrl == '0) begin
      fmt = FMT_DATA;
    end else if (sop_lo) begin
      fmt    = FMT_SOP_LO;
      keep_c = '0;
    end else if (sop_hi) begin
      fmt    = FMT_SOP_HI;
      keep_c = grp_ctrl & ~(LO_ONE << LANES);
    end else if (eop) begin
      fmt    = FMT_EOP_BASE + FMT_W'(first);
      keep_c = grp_ctrl & ~(LO_ONE << first);
    end else if (gap) begin
      fmt = FMT_GAP;
    end else begin
      fmt    = FMT_BAD;
      keep_d = '0;
      keep_c = ALL1;
    end
  end
endmodule

// File: rtl/mixblk_pack.sv
module mixblk_pack
  import mixblk_pkg::*;
(
  input  logic [FMT_W-1:0]         fmt,
  input  logic [GRP_W-1:0]         grp_data,
  input  logic [OCTETS-1:0]        keep_d,
  input  logic [OCTETS-1:0]        keep_c,
  input  logic [OCTETS*CODE_W-1:0] codes,
  output logic [BLK_W-1:0]         blk
);
  localparam int CACC_W = OCTETS * CODE_W;

  logic [BODY_W-1:0] dacc;
  logic [CACC_W-1:0] cacc;
  logic [PAY_W-1:0]  pay;
  int                nd;

  always_comb begin
    dacc = '0;
    cacc = '0;
    nd   = 0;
    for (int o = 0; o < OCTETS; o++) begin
      if (keep_d[o]) begin
        dacc = {dacc[BODY_W-BYTE_W-1:0], grp_data[o*BYTE_W +: BYTE_W]};
        nd   = nd + 1;
      end
      if (keep_c[o]) begin
        cacc = {cacc[CACC_W-CODE_W-1:0],
                (fmt == FMT_BAD) ? C7_ERR : codes[o*CODE_W +: CODE_W]};
      end
    end
    if (nd > OCTETS - 1) nd = OCTETS - 1;

    if (fmt == FMT_DATA) begin
      for (int o = 0; o < OCTETS; o++)
        pay[PAY_W-1-o*BYTE_W -: BYTE_W] = grp_data[o*BYTE_W +: BYTE_W];
      blk = {HDR_DATA, pay};
    end else begin
      pay = {type_of(fmt), (dacc << (BYTE_W * (OCTETS - 1 - nd))) | cacc};
      blk = {HDR_MIXED, pay};
    end
  end
endmodule

// File: rtl/mixblk_encoder.sv
module mixblk_encoder
  import mixblk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*BYTE_W-1:0] in_data,
  input  logic [LANES-1:0]        in_ctrl,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [BLK_W-1:0]        out_block
);
  logic                    take, grp_last;
  logic [GRP_W-1:0]        grp_data;
  logic [OCTETS-1:0]       grp_ctrl, keep_d, keep_c;
  logic [FMT_W-1:0]        fmt;
  logic [OCTETS*CODE_W-1:0] codes;
  logic [BLK_W-1:0]        blk;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  mixblk_gather u_gather (
    .clk(clk), .rst_n(rst_n), .take(take), .in_data(in_data), .in_ctrl(in_ctrl),
    .grp_data(grp_data), .grp_ctrl(grp_ctrl), .grp_last(grp_last)
  );

  mixblk_classify u_classify (
    .grp_data(grp_data), .grp_ctrl(grp_ctrl), .fmt(fmt),
    .keep_d(keep_d), .keep_c(keep_c), .codes(codes)
  );

  mixblk_pack u_pack (
    .fmt(fmt), .grp_data(grp_data), .keep_d(keep_d), .keep_c(keep_c),
    .codes(codes), .blk(blk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_block <= '0;
    end else if (grp_last) begin
      out_valid <= 1'b1;
      out_block <= blk;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mixblk_encoder_chk.sv
module mixblk_encoder_chk
  import mixblk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BLK_W-1:0] out_block
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_block));

  // R10
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R1
  issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R3
  hdr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_block[BLK_W-1 -: HDR_W] == HDR_DATA) ||
                  (out_block[BLK_W-1 -: HDR_W] == HDR_MIXED));

  // R3
  type_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_block[BLK_W-1 -: HDR_W] == HDR_MIXED
      |-> ($countones(out_block[PAY_W-1 -: BYTE_W]) % 2) == 0);

  // R3
  type_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_block[BLK_W-1 -: HDR_W] == HDR_MIXED
      |-> out_block[PAY_W-1 -: FMT_W] >= FMT_SOP_LO &&
          out_block[PAY_W-1 -: FMT_W] <= FMT_GAP);
endmodule

bind mixblk_encoder mixblk_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_block(out_block)
);

// File: tb/tb_mixblk_encoder.sv
`timescale 1ns/1ps
module tb_mixblk_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [3:0]  in_ctrl = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [65:0] out_block;

  always #2.5 clk = ~clk;

  mixblk_encoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctrl(in_ctrl), .out_valid(out_valid),
    .out_ready(out_ready), .out_block(out_block)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] q_d[$];
  logic [3:0]  q_c[$];
  logic [65:0] exp_blk[$];
  string       exp_tag[$];

  task automatic check(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_code(input logic [7:0] b);
    case (b)
      8'hBC: return 'h00;
      8'h1C: return 'h01;
      8'hFE: return 'h1E;
      8'hFB: return 'h2B;
      8'hFD: return 'h2D;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] m_type(input int f);
    logic [3:0] n;
    logic [6:0] s;
    n = f[3:0];
    s = {n, n[0]^n[1]^n[3], n[0]^n[2]^n[3], n[1]^n[2]^n[3]};
    return {s, ^s};
  endfunction

  function automatic string tag_of(input int f);
    if (f == 0) return "R1 R2";
    if (f <= 2) return "R1 R3 R4 R7 R8";
    if (f <= 10) return "R1 R3 R5 R8";
    if (f == 11) return "R1 R3 R6 R7 R8";
    return "R1 R9";
  endfunction

  // returns {format index, block}
  function automatic logic [69:0] model(input logic [63:0] d, input logic [7:0] c);
    logic [63:0] pay;
    int f, p, pos, n;
    int idx[8];
    bit allv;
    allv = 1'b1;
    for (int o = 0; o < 8; o++)
      if (c[o] && m_code(d[8*o +: 8]) < 0) allv = 1'b0;
    p = 0;
    for (int o = 7; o >= 0; o--) if (c[o]) p = o;
    f = 12;
    if (c == 8'h00) f = 0;
    else if (c == 8'h01 && d[7:0] == 8'hFB) f = 1;
    else if (c == 8'h1F && allv && d[39:32] == 8'hFB) f = 2;
    else if (allv && d[8*p +: 8] == 8'hFD && c == (8'hFF << p)) f = 3 + p;
    else if (c == 8'hFF && allv) f = 11;
    pay = '0;
    if (f == 0) begin
      for (int o = 0; o < 8; o++) pay[63-8*o -: 8] = d[8*o +: 8];
      return {4'(f), 2'b01, pay};
    end
    pay[63:56] = m_type(f == 12 ? 11 : f);
    pos = 55;
    n = 0;
    for (int o = 0; o < 8; o++) begin
      if (c[o] || f == 12) begin
        if (!((f == 1 && o == 0) || (f == 2 && o == 4) || (f >= 3 && f <= 10 && o == f - 3))) begin
          idx[n] = o;
          n++;
        end
      end else begin
        pay[pos -: 8] = d[8*o +: 8];
        pos -= 8;
      end
    end
    for (int k = 0; k < n; k++) begin
      int v;
      v = (f == 12) ? 'h1E : m_code(d[8*idx[k] +: 8]);
      pay[(n-k)*7-1 -: 7] = v[6:0];
    end
    return {4'(f), 2'b10, pay};
  endfunction

  task automatic push_group(input logic [63:0] d, input logic [7:0] c);
    q_d.push_back(d[31:0]);  q_c.push_back(c[3:0]);
    q_d.push_back(d[63:32]); q_c.push_back(c[7:4]);
  endtask

  function automatic logic [7:0] zc();
    case ($urandom % 3)
      0: return 8'hBC;
      1: return 8'h1C;
      default: return 8'hFE;
    endcase
  endfunction

  function automatic logic [7:0] anyc();
    case ($urandom % 5)
      0: return 8'hBC;
      1: return 8'h1C;
      2: return 8'hFE;
      3: return 8'hFB;
      default: return 8'hFD;
    endcase
  endfunction

  task automatic rand_group();
    logic [63:0] d;
    logic [7:0]  c;
    int p;
    d = {$urandom, $urandom};
    c = '0;
    case ($urandom % 8)
      0: ;
      1: begin c = 8'h01; d[7:0] = 8'hFB; end
      2: begin
        c = 8'h1F;
        for (int o = 0; o < 4; o++) d[8*o +: 8] = zc();
        d[39:32] = 8'hFB;
      end
      3: begin
        p = $urandom % 8;
        c = 8'hFF << p;
        d[8*p +: 8] = 8'hFD;
        for (int o = p + 1; o < 8; o++) d[8*o +: 8] = zc();
      end
      4: begin
        c = 8'hFF;
        for (int o = 0; o < 8; o++) d[8*o +: 8] = anyc();
      end
      5: begin
        c = 8'hFF;
        for (int o = 0; o < 8; o++) d[8*o +: 8] = anyc();
        p = $urandom % 8;
        d[8*p +: 8] = 8'h55;
      end
      6: begin
        c = 8'($urandom);
        for (int o = 0; o < 8; o++) if (c[o]) d[8*o +: 8] = anyc();
      end
      default: begin
        p = 1 + ($urandom % 7);
        c = 8'h01 | (8'h01 << p);
        d[7:0] = 8'hFB;
        d[8*p +: 8] = zc();
      end
    endcase
    push_group(d, c);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int idx;
    int cyc;
    bit stall_pend;
    logic [65:0] held;
    logic [69:0] mv;
    void'($urandom(32'd4242));

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: half a group, then reset; the next group must start fresh
    in_valid = 1'b1;
    in_data  = 32'hDEADBEEF;
    in_ctrl  = 4'h0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R11 out_valid after reset", 66'(out_valid), 66'd0);
    check(in_ready == 1'b1, "R11 in_ready after reset", 66'(in_ready), 66'd1);

    // directed: all idle-even gap (R6 R7 R11)
    push_group({8{8'hBC}}, 8'hFF);
    exp_blk.push_back({2'b10, 8'hB8, 56'h0});
    exp_tag.push_back("R6 R7 R11 directed gap");
    // directed: terminate at octet 7 (R5 R8)
    push_group(64'hFD070605_04030201, 8'h80);
    exp_blk.push_back({2'b10, 8'hA5, 56'h01020304050607});
    exp_tag.push_back("R5 R8 directed end p=7");
    // directed: start in second transfer (R4 R7 R8)
    push_group(64'hCCBBAAFB_BCFE1CBC, 8'h1F);
    exp_blk.push_back({2'b10, 8'h2B, 56'hAABBCC00004F00});
    exp_tag.push_back("R4 R7 R8 directed start hi");

    for (int g = 0; g < 2500; g++) rand_group();

    idx = 0;
    cyc = 0;
    stall_pend = 1'b0;
    held = '0;
    while ((idx < q_d.size() || exp_blk.size() != 0) && cyc < 150000) begin
      out_ready = ($urandom % 4) != 0;
      if (idx < q_d.size()) begin
        in_valid = ($urandom % 5) != 0;
        in_data  = q_d[idx];
        in_ctrl  = q_c[idx];
      end else begin
        in_valid = 1'b0;
      end
      #1;
      // R10 ready rule
      check(in_ready == (!out_valid || out_ready), "R10 in_ready rule",
            66'(in_ready), 66'(!out_valid || out_ready));
      if (stall_pend)
        check(out_valid && out_block == held, "R10 held block", out_block, held);
      stall_pend = out_valid && !out_ready;
      held = out_block;
      if (out_valid && out_ready) begin
        if (exp_blk.size() == 0) begin
          check(1'b0, "R1 unexpected block", out_block, '0);
        end else begin
          logic [65:0] e;
          string t;
          e = exp_blk.pop_front();
          t = exp_tag.pop_front();
          check(out_block == e, t, out_block, e);
        end
      end
      if (in_valid && in_ready) begin
        if (idx % 2 == 1 && idx >= 7) begin
          mv = model({q_d[idx], q_d[idx-1]}, {q_c[idx], q_c[idx-1]});
          exp_blk.push_back(mv[65:0]);
          exp_tag.push_back(tag_of(int'(mv[69:66])));
        end
        idx++;
      end
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 150000) check(1'b0, "R1 stream did not drain", 66'(exp_blk.size()), 66'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule